// File: doc/BRIEF.md
# Multi-Source Register Transfer Unit

This unit carries out register-to-register moves in an 18-bit word machine. A single start strobe launches one transfer. The transfer gathers any set of sources onto one intermediate word by a bitwise OR. It passes that word through one of five simple operations (copy, ones complement, or a fixed shift) and writes the result into every selected destination at the same clock edge. The sources are the A, B, C-counter, Q and Q-counter words, the operator switch bank, the receive line register and the transmit line register. Every transfer also refreshes the sign, zero and parity status flags.

The switch bank, the receive register and the transmit register are 21 bits wide. Their three upper bits pass through three extension flip-flops that form the top of the transmit register. Reading the receive register raises a one-cycle clear pulse toward the receive interface. Writing the transmit register first raises a one-cycle clear pulse toward the transmit interface and empties the transmit register. Only after that does the write land.

Top module: `reg_xfer_unit`

## Requirements
- R1: The intermediate word is the bitwise OR of every source whose bit is set in `fromMask` (bit 0 A, 1 B, 2 C counter, 3 Q, 4 Q counter, 5 switches, 6 receive data, 7 transmit register). When no bit is set, the word is zero.
- R2: The result is written in one edge to every destination set in `toMask` (bit 0 A, 1 B, 2 C counter, 3 Q, 4 Q counter, 5 transmit register). When `toMask` is zero, no register changes. Unselected registers keep their value.
- R3: `opcode` 0 copies, 1 complements, 2 shifts left by one, 3 shifts right by one and 4 shifts left by six. Shifts fill with zeros and drop the bits shifted out. Codes 5 to 7 behave as code 0. The operation acts on the low 18 bits only.
- R4: After each transfer, `flagZero` is 1 when the 18-bit result is zero, `flagPlus` is 1 when its bit 17 is 0, and `flagEven` is 1 when it holds an even number of ones.
- R5: The extension bits 20:18 of the switches, receive data and transmit register are ORed the same way and pass through every operation unchanged. They are loaded into `txData[20:18]` whenever the transmit register is a destination.
- R6: `done` is a one-cycle pulse. It comes two cycles after the start edge, or three when the transmit register is a destination. The written values are visible in the `done` cycle.
- R7: When the transmit register is a destination, `txClear` pulses for one cycle in the cycle after the start edge and empties the transmit register. A transmit source in that same transfer therefore contributes zero.
- R8: When the receive register is a source, `rxClear` pulses for one cycle together with `done`. Otherwise it stays low.
- R9: A start strobe that arrives while a transfer is in progress is ignored.
- R10: After reset, all registers are zero, all three flags are 1, and `done`, `txClear` and `rxClear` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | One-cycle strobe that begins a transfer |
| opcode | input | 3 | Operation applied on the way to the destinations |
| fromMask | input | 8 | Source selection, one bit per source |
| toMask | input | 6 | Destination selection, one bit per destination |
| switches | input | 21 | Operator switch bank |
| rxData | input | 21 | Receive line register contents |
| regA | output | 18 | A register |
| regB | output | 18 | B register |
| regC | output | 18 | C counter |
| regQ | output | 18 | Q register |
| regQCnt | output | 18 | Q counter |
| txData | output | 21 | Transmit line register, extension bits on top |
| flagPlus | output | 1 | Result sign bit clear |
| flagZero | output | 1 | Result all zero |
| flagEven | output | 1 | Result has even parity |
| done | output | 1 | Transfer finished pulse |
| rxClear | output | 1 | Clear pulse to the receive interface |
| txClear | output | 1 | Clear pulse to the transmit interface |

## Verification
The captured masks and opcode hold the state of the unit. A wrong mask bit shows in the `done` cycle. It appears as a destination that kept its old value, or as a register that changed when it should not have. A wrong latched opcode shows as a shifted or inverted result in that same cycle. A wrong sequencer state shows earlier, in the cycle right after the start edge, as a missing or extra `txClear`, or as `done` arriving one cycle off. Stale extension flip-flops show only at `txData[20:18]` after the next write to the transmit register. For that reason the vectors write the transmit register with different extension patterns.

// File: rtl/rtu_pkg.sv
package rtu_pkg;
  localparam int SRC_CNT  = 8;
  localparam int WREG_CNT = 5;
  localparam int DST_CNT  = WREG_CNT + 1;
  localparam int SRC_SW   = 5;
  localparam int SRC_RX   = 6;
  localparam int SRC_TX   = 7;
  localparam int DST_TX   = 5;

  localparam logic [2:0] OP_TRA = 3'd0;
  localparam logic [2:0] OP_TRC = 3'd1;
  localparam logic [2:0] OP_SL1 = 3'd2;
  localparam logic [2:0] OP_SR1 = 3'd3;
  localparam logic [2:0] OP_SL6 = 3'd4;

  typedef struct packed {
    logic txClr;
    logic wrEn;
    logic done;
    logic rxClr;
  } rtu_strobe_t;
endpackage

// File: rtl/rtu_control.sv
module rtu_control
  import rtu_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               start,
  input  logic [2:0]         opIn,
  input  logic [SRC_CNT-1:0] fromIn,
  input  logic [DST_CNT-1:0] toIn,
  output logic [2:0]         opSel,
  output logic [SRC_CNT-1:0] fromSel,
  output logic [DST_CNT-1:0] toSel,
  output rtu_strobe_t        strobe
);
  typedef enum logic [1:0] {ST_IDLE, ST_CLRT, ST_WRITE, ST_FIN} state_t;
  state_t state, nextState;

  always_comb begin
    nextState = state;
    case (state)
      ST_IDLE:  if (start) nextState = toIn[DST_TX] ? ST_CLRT : ST_WRITE;
      ST_CLRT:  nextState = ST_WRITE;
      ST_WRITE: nextState = ST_FIN;
      default:  nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      opSel   <= OP_TRA;
      fromSel <= '0;
      toSel   <= '0;
    end else begin
      state <= nextState;
      if (state == ST_IDLE && start) begin
        opSel   <= opIn;
        fromSel <= fromIn;
        toSel   <= toIn;
      end
    end
  end

  always_comb begin
    strobe.txClr = (state == ST_CLRT);
    strobe.wrEn  = (state == ST_WRITE);
    strobe.done  = (state == ST_FIN);
    strobe.rxClr = (state == ST_FIN) && fromSel[SRC_RX];
  end
endmodule

// File: rtl/rtu_datapath.sv
module rtu_datapath
  import rtu_pkg::*;
#(
  parameter int WORD_W    = 18,
  parameter int EXT_W     = 3,
  parameter int BIG_SHIFT = 6,
  localparam int FULL_W   = WORD_W + EXT_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  rtu_strobe_t        strobe,
  input  logic [2:0]         opSel,
  input  logic [SRC_CNT-1:0] fromSel,
  input  logic [DST_CNT-1:0] toSel,
  input  logic [FULL_W-1:0]  switches,
  input  logic [FULL_W-1:0]  rxData,
  output logic [WORD_W-1:0]  wordOut [WREG_CNT],
  output logic [FULL_W-1:0]  txData,
  output logic               flagPlus,
  output logic               flagZero,
  output logic               flagEven
);
  logic [WORD_W-1:0] wordReg [WREG_CNT];
  logic [WORD_W-1:0] txLow;
  logic [EXT_W-1:0]  extFf;
  logic [FULL_W-1:0] srcWord [SRC_CNT];
  logic [FULL_W-1:0] gated   [SRC_CNT];
  logic [FULL_W-1:0] yWord;
  logic [WORD_W-1:0] zLow;
  logic [EXT_W-1:0]  zExt;

  assign txData = {extFf, txLow};

  // Source bus: every word register widened, line registers at full width
  for (genvar i = 0; i < WREG_CNT; i++) begin : g_wsrc
    assign srcWord[i] = {{EXT_W{1'b0}}, wordReg[i]};
    assign wordOut[i] = wordReg[i];
  end
  assign srcWord[SRC_SW] = switches;
  assign srcWord[SRC_RX] = rxData;
  assign srcWord[SRC_TX] = txData;

  for (genvar i = 0; i < SRC_CNT; i++) begin : g_gate
    assign gated[i] = fromSel[i] ? srcWord[i] : '0;
  end

  always_comb begin
    yWord = '0;
    for (int i = 0; i < SRC_CNT; i++) yWord = yWord | gated[i];
  end

  // Operation stage: low word transformed, extension passes straight
  always_comb begin
    case (opSel)
      OP_TRC:  zLow = ~yWord[WORD_W-1:0];
      OP_SL1:  zLow = yWord[WORD_W-1:0] << 1;
      OP_SR1:  zLow = yWord[WORD_W-1:0] >> 1;
      OP_SL6:  zLow = yWord[WORD_W-1:0] << BIG_SHIFT;
      default: zLow = yWord[WORD_W-1:0];
    endcase
    zExt = yWord[FULL_W-1:WORD_W];
  end

  for (genvar i = 0; i < WREG_CNT; i++) begin : g_wreg
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                         wordReg[i] <= '0;
      else if (strobe.wrEn && toSel[i])  wordReg[i] <= zLow;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txLow <= '0;
      extFf <= '0;
    end else if (strobe.txClr) begin
      txLow <= '0;
      extFf <= '0;
    end else if (strobe.wrEn && toSel[DST_TX]) begin
      txLow <= zLow;
      extFf <= zExt;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flagPlus <= 1'b1;
      flagZero <= 1'b1;
      flagEven <= 1'b1;
    end else if (strobe.wrEn) begin
      flagPlus <= ~zLow[WORD_W-1];
      flagZero <= (zLow == '0);
      flagEven <= ~(^zLow);
    end
  end
endmodule

// File: rtl/reg_xfer_unit.sv
module reg_xfer_unit
  import rtu_pkg::*;
#(
  parameter int WORD_W    = 18,
  parameter int EXT_W     = 3,
  parameter int BIG_SHIFT = 6,
  localparam int FULL_W   = WORD_W + EXT_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               start,
  input  logic [2:0]         opcode,
  input  logic [SRC_CNT-1:0] fromMask,
  input  logic [DST_CNT-1:0] toMask,
  input  logic [FULL_W-1:0]  switches,
  input  logic [FULL_W-1:0]  rxData,
  output logic [WORD_W-1:0]  regA,
  output logic [WORD_W-1:0]  regB,
  output logic [WORD_W-1:0]  regC,
  output logic [WORD_W-1:0]  regQ,
  output logic [WORD_W-1:0]  regQCnt,
  output logic [FULL_W-1:0]  txData,
  output logic               flagPlus,
  output logic               flagZero,
  output logic               flagEven,
  output logic               done,
  output logic               rxClear,
  output logic               txClear
);
  rtu_strobe_t        ctrlStrobe;
  logic [2:0]         opSel;
  logic [SRC_CNT-1:0] fromSel;
  logic [DST_CNT-1:0] toSel;
  logic [WORD_W-1:0]  wordOut [WREG_CNT];

  rtu_control ctrl_i (
    .clk(clk), .rstN(rstN), .start(start), .opIn(opcode),
    .fromIn(fromMask), .toIn(toMask), .opSel(opSel),
    .fromSel(fromSel), .toSel(toSel), .strobe(ctrlStrobe)
  );

  rtu_datapath #(.WORD_W(WORD_W), .EXT_W(EXT_W), .BIG_SHIFT(BIG_SHIFT)) dp_i (
    .clk(clk), .rstN(rstN), .strobe(ctrlStrobe), .opSel(opSel),
    .fromSel(fromSel), .toSel(toSel), .switches(switches), .rxData(rxData),
    .wordOut(wordOut), .txData(txData), .flagPlus(flagPlus),
    .flagZero(flagZero), .flagEven(flagEven)
  );

  assign regA    = wordOut[0];
  assign regB    = wordOut[1];
  assign regC    = wordOut[2];
  assign regQ    = wordOut[3];
  assign regQCnt = wordOut[4];
  assign done    = ctrlStrobe.done;
  assign rxClear = ctrlStrobe.rxClr;
  assign txClear = ctrlStrobe.txClr;
endmodule

// File: rtl/rtu_checker.sv
module rtu_checker #(
  parameter int WORD_W = 18,
  parameter int FULL_W = 21
) (
  input logic              clk,
  input logic              rstN,
  input logic              done,
  input logic              rxClear,
  input logic              txClear,
  input logic              wrEn,
  input logic [WORD_W-1:0] regA,
  input logic [FULL_W-1:0] txData
);
  a_r6_done_one_cycle: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  a_r6_done_after_write: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |=> done);
  a_r8_rxclr_with_done: assert property (@(posedge clk) disable iff (!rstN)
    rxClear |-> done);
  a_r7_txclr_then_write: assert property (@(posedge clk) disable iff (!rstN)
    txClear |=> (wrEn && !txClear));
  a_r7_tx_emptied: assert property (@(posedge clk) disable iff (!rstN)
    txClear |=> (txData == '0));
  a_r2_a_holds: assert property (@(posedge clk) disable iff (!rstN)
    !wrEn |=> $stable(regA));
  a_r2_tx_holds: assert property (@(posedge clk) disable iff (!rstN)
    (!wrEn && !txClear) |=> $stable(txData));
endmodule

bind reg_xfer_unit rtu_checker #(.WORD_W(WORD_W), .FULL_W(FULL_W)) chk_i (
  .clk(clk), .rstN(rstN), .done(done), .rxClear(rxClear),
  .txClear(txClear), .wrEn(ctrlStrobe.wrEn), .regA(regA), .txData(txData)
);

// File: tb/reg_xfer_unit_tb_top.sv
`timescale 1ns/1ps
module reg_xfer_unit_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [2:0]  opcode = '0;
  logic [7:0]  fromMask = '0;
  logic [5:0]  toMask = '0;
  logic [20:0] switches = '0;
  logic [20:0] rxData = '0;
  logic [17:0] regA, regB, regC, regQ, regQCnt;
  logic [20:0] txData;
  logic        flagPlus, flagZero, flagEven, done, rxClear, txClear;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #2.5 clk = ~clk;

  reg_xfer_unit dut_i (
    .clk(clk), .rstN(rstN), .start(start), .opcode(opcode),
    .fromMask(fromMask), .toMask(toMask), .switches(switches),
    .rxData(rxData), .regA(regA), .regB(regB), .regC(regC), .regQ(regQ),
    .regQCnt(regQCnt), .txData(txData), .flagPlus(flagPlus),
    .flagZero(flagZero), .flagEven(flagEven), .done(done),
    .rxClear(rxClear), .txClear(txClear)
  );

  // source mask bits: A B C Q QC SW RX TX ; destination bits: A B C Q QC TX
  localparam logic [7:0] FA = 8'h01, FB = 8'h02, FC = 8'h04, FQ = 8'h08;
  localparam logic [7:0] FS = 8'h20, FR = 8'h40, FT = 8'h80;
  localparam logic [5:0] TA = 6'h01, TB = 6'h02, TC = 6'h04, TQ = 6'h08;
  localparam logic [5:0] TQC = 6'h10, TT = 6'h20;

  typedef struct packed {
    logic [2:0]  op;
    logic [7:0]  fromM;
    logic [5:0]  toM;
    logic [20:0] sw;
    logic [20:0] rx;
    logic [17:0] z;
    logic [2:0]  zExt;
    logic        plus;
    logic        zero;
    logic        even;
  } vec_t;

  localparam int NVEC = 15;
  localparam vec_t VECS [NVEC] = '{
    '{3'd0, FS,       TA,      21'h000F0F, 21'h0,      18'h00F0F, 3'b000, 1'b1, 1'b0, 1'b1},
    '{3'd0, FS,       TB|TC,   21'h030001, 21'h0,      18'h30001, 3'b000, 1'b0, 1'b0, 1'b0},
    '{3'd1, FS,       TQ,      21'h03FFFF, 21'h0,      18'h00000, 3'b000, 1'b1, 1'b1, 1'b1},
    '{3'd2, FA|FQ,    TQC,     21'h0,      21'h0,      18'h01E1E, 3'b000, 1'b1, 1'b0, 1'b1},
    '{3'd3, FB,       TA,      21'h0,      21'h0,      18'h18000, 3'b000, 1'b1, 1'b0, 1'b1},
    '{3'd4, FC,       TB,      21'h0,      21'h0,      18'h00040, 3'b000, 1'b1, 1'b0, 1'b0},
    '{3'd0, FR,       TT,      21'h0,      21'h152345, 18'h12345, 3'b101, 1'b1, 1'b0, 1'b0},
    '{3'd0, FA|FB,    6'h00,   21'h0,      21'h0,      18'h18040, 3'b000, 1'b1, 1'b0, 1'b0},
    '{3'd1, 8'h00,    TC,      21'h03FFFF, 21'h0,      18'h3FFFF, 3'b000, 1'b0, 1'b0, 1'b1},
    '{3'd0, FT|FA,    TT,      21'h0,      21'h0,      18'h18000, 3'b000, 1'b1, 1'b0, 1'b1},
    '{3'd2, FC,       TA,      21'h0,      21'h0,      18'h3FFFE, 3'b000, 1'b0, 1'b0, 1'b0},
    '{3'd3, FC,       TB,      21'h0,      21'h0,      18'h1FFFF, 3'b000, 1'b1, 1'b0, 1'b0},
    '{3'd5, FQ,       TQC,     21'h0,      21'h0,      18'h00000, 3'b000, 1'b1, 1'b1, 1'b1},
    '{3'd1, FS,       TT,      21'h080000, 21'h0,      18'h3FFFF, 3'b010, 1'b0, 1'b0, 1'b1},
    '{3'd0, FS|FR|FA, TT|TQ,   21'h040003, 21'h100100, 18'h3FFFF, 3'b101, 1'b0, 1'b0, 1'b1}
  };

  logic [17:0] shw [5];
  logic [20:0] shTx;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic checkRegs(input string tag);
    chk({tag, " R2 A"},  {14'd0, regA},    {14'd0, shw[0]});
    chk({tag, " R2 B"},  {14'd0, regB},    {14'd0, shw[1]});
    chk({tag, " R2 C"},  {14'd0, regC},    {14'd0, shw[2]});
    chk({tag, " R2 Q"},  {14'd0, regQ},    {14'd0, shw[3]});
    chk({tag, " R2 QC"}, {14'd0, regQCnt}, {14'd0, shw[4]});
    chk({tag, " R5 TX"}, {11'd0, txData},  {11'd0, shTx});
  endtask

  // launch a transfer; returns latency to done and pulse counts (sampled at negedge)
  task automatic runOp(input logic [2:0] op, input logic [7:0] fm, input logic [5:0] tm,
                       input logic [20:0] sw, input logic [20:0] rx,
                       output int lat, output int clrCnt, output int rxCnt,
                       output logic clrFirst, output logic rxAtDone);
    @(negedge clk);
    opcode = op; fromMask = fm; toMask = tm; switches = sw; rxData = rx; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 1; clrCnt = int'(txClear); rxCnt = int'(rxClear); clrFirst = txClear;
    while (!done && lat < 10) begin
      @(negedge clk);
      lat++;
      clrCnt += int'(txClear);
      rxCnt  += int'(rxClear);
    end
    rxAtDone = rxClear;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=%0d expected<=20000", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int lat, clrCnt, rxCnt;
    logic clrFirst, rxAtDone;
    for (int i = 0; i < 5; i++) shw[i] = '0;
    shTx = '0;
    repeat (3) @(negedge clk);
    // R10: reset state
    chk("R10 flags", {29'd0, flagPlus, flagZero, flagEven}, 32'd7);
    chk("R10 pulses", {29'd0, done, rxClear, txClear}, 32'd0);
    checkRegs("R10");
    rstN = 1'b1;
    @(negedge clk);

    // Vector walk: R1 merge, R3 operations, R4 flags, R5 extension, R6 R7 R8 timing
    for (int v = 0; v < NVEC; v++) begin
      runOp(VECS[v].op, VECS[v].fromM, VECS[v].toM, VECS[v].sw, VECS[v].rx,
            lat, clrCnt, rxCnt, clrFirst, rxAtDone);
      for (int i = 0; i < 5; i++)
        if (VECS[v].toM[i]) shw[i] = VECS[v].z;
      if (VECS[v].toM[5]) shTx = {VECS[v].zExt, VECS[v].z};
      checkRegs($sformatf("vec%0d R1 R3", v));
      chk($sformatf("vec%0d R4 flags", v), {29'd0, flagPlus, flagZero, flagEven},
          {29'd0, VECS[v].plus, VECS[v].zero, VECS[v].even});
      chk($sformatf("vec%0d R6 latency", v), lat, VECS[v].toM[5] ? 3 : 2);
      chk($sformatf("vec%0d R7 txClear count", v), clrCnt, VECS[v].toM[5] ? 1 : 0);
      chk($sformatf("vec%0d R7 txClear first cycle", v), {31'd0, clrFirst}, {31'd0, VECS[v].toM[5]});
      chk($sformatf("vec%0d R8 rxClear at done", v), {31'd0, rxAtDone}, {31'd0, VECS[v].fromM[6]});
      chk($sformatf("vec%0d R8 rxClear count", v), rxCnt, VECS[v].fromM[6] ? 1 : 0);
      @(negedge clk);
      chk($sformatf("vec%0d R6 done single", v), {31'd0, done}, 32'd0);
    end

    // R9: a second start during a transmit transfer is ignored
    @(negedge clk);
    opcode = 3'd0; fromMask = FS; toMask = TT; switches = 21'h000555; start = 1'b1;
    @(negedge clk);
    opcode = 3'd1; toMask = TA; start = 1'b1;  // arrives in the clear cycle
    @(negedge clk);
    start = 1'b0;
    chk("R9 no early done", {31'd0, done}, 32'd0);
    @(negedge clk);
    chk("R9 done once", {31'd0, done}, 32'd1);
    shTx = 21'h000555;
    checkRegs("R9");
    chk("R9 flags", {29'd0, flagPlus, flagZero, flagEven}, 32'd5);
    repeat (4) begin
      @(negedge clk);
      chk("R9 no second done", {31'd0, done}, 32'd0);
    end
    checkRegs("R9 after");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule